// File: doc/BRIEF.md
# Indexed Block-Transfer Configuration Register Slave

This block is a two-wire serial slave that sits beside the clock-control logic of a chip. It holds a bank of eight 8-bit configuration bytes and presents them all at once on a parallel output bus. A host reaches the bank through indexed block transfers. Every transaction names a starting index. A write also carries an explicit byte count. On a read, the slave answers with that count before it sends any register data.

SCL and SDA are sampled by the system clock through synchronizer flops. Start, stop, edges and bit timing are all derived inside the system-clock domain. The slave never drives SDA high. It only asserts an open-drain enable that pulls the line low. Two frequency-select pins are synchronized and appear as read-only status in register 0. Register 7 returns a fixed identification byte. Some bits of the writable registers are reserved, and these keep their value no matter what the host writes.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges only the 8-bit address D2h (write) and D3h (read), which is the 7-bit address 69h. Any other address byte gets no acknowledge, and the slave ignores the bus until the next start.
- R2: A write frame is start, D2h, index N, count X, then data bytes. Each byte is acknowledged. Data byte k goes to register N+k, and the new value is visible on `cfg_o` before the next byte begins.
- R3: Data bytes past the first X in a write frame are acknowledged and discarded.
- R4: The register pointer saturates at the value 8, which means "beyond the last register". An index byte of 8 or more sets the pointer to 8. At that position writes are acknowledged and dropped, and reads return 00h.
- R5: A read frame is start, D2h, index N, repeated start, D3h. The slave first sends the count stored by the most recent write frame (08h after reset), then the registers from N upward, advancing one register for each byte the host acknowledges.
- R6: When the host does not acknowledge a read byte, the slave leaves SDA released until the next start or stop.
- R7: Register 7 is read-only and reads {REV_ID, VEND_ID}, which is 21h by default. Register 0 is read-only: bit 0 is fsel_i[0] and bit 1 is fsel_i[1], both after synchronization, and bits 7:2 read 0.
- R8: Reserved bits ignore writes and read 0. These are register 1 bits 5:3, register 2 bits 2:0, and register 6 bits 6 and 3. The write masks are 1=C7h, 2=F8h, 3/4/5=FFh, 6=B7h.
- R9: After reset the registers 0..7 read 02h (with fsel_i=10b), 47h, 00h, FFh, C7h, DFh, 03h, 21h.
- R10: A start or stop inside a byte abandons that byte without writing it. Bytes that already completed stay written. The slave releases SDA after a stop and accepts the next frame normally.
- R11: The slave changes its SDA drive only while SCL is low. The one exception is a release caused by a start or stop. An acknowledge is held for the whole SCL high phase.
- R12: `cfg_o` bits 8i+7:8i carry register i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| fsel_i | input | 2 | Frequency-select pin levels, read back in register 0 |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| cfg_o | output | 64 | Register bank, register i in bits 8i+7:8i |

## Verification
A wrong pointer or field state shows up within a single byte time of nine SCL periods. It appears either as a missing acknowledge or as wrong bits in the next byte the slave sends. Read-back frames therefore compare every returned byte, including the echoed count. A wrong write commit reaches `cfg_o` one system clock after the acknowledge decision. The bench checks the parallel bus after each frame, and it checks that registers the frame should not touch are unchanged.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  parameter int unsigned REG_COUNT = 8;
  parameter int unsigned BYTE_W    = 8;
  localparam int unsigned PTR_W    = $clog2(REG_COUNT) + 1;

  typedef enum logic [2:0] {
    LK_IDLE, LK_RX, LK_RX_ACK, LK_TX, LK_TX_ACK, LK_SKIP
  } link_st_t;

  typedef enum logic [1:0] {
    FD_ADDR, FD_INDEX, FD_COUNT, FD_DATA
  } field_t;

  // bits the host may change, per register
  function automatic logic [BYTE_W-1:0] wr_mask(input int idx);
    case (idx)
      1:       return 8'hC7;
      2:       return 8'hF8;
      3, 4, 5: return 8'hFF;
      6:       return 8'hB7;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] rst_val(input int idx);
    case (idx)
      1:       return 8'h47;
      3:       return 8'hFF;
      4:       return 8'hC7;
      5:       return 8'hDF;
      6:       return 8'h03;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int unsigned  W       = 1,
  parameter int unsigned  STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= RST_VAL;
          else        pipe[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= RST_VAL;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_cfg_pkg::*;
#(
  parameter logic [3:0] REV_ID  = 4'h2,
  parameter logic [3:0] VEND_ID = 4'h1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [PTR_W-1:0]            idx,
  input  logic [BYTE_W-1:0]           wr_data,
  input  logic [1:0]                  fsel,
  output logic [BYTE_W-1:0]           rd_data,
  output logic [REG_COUNT*BYTE_W-1:0] cfg_flat
);
  logic [BYTE_W-1:0] bytes [REG_COUNT];

  genvar i;
  generate
    for (i = 0; i < REG_COUNT; i++) begin : g_reg
      if (i == 0) begin : g_status
        assign bytes[i] = {{(BYTE_W-2){1'b0}}, fsel};
      end else if (i == REG_COUNT - 1) begin : g_ident
        assign bytes[i] = {REV_ID, VEND_ID};
      end else begin : g_rw
        localparam logic [BYTE_W-1:0] MASK = wr_mask(i);
        localparam logic [BYTE_W-1:0] INIT = rst_val(i);
        logic [BYTE_W-1:0] val_q, val_d;
        logic              hit;
        assign hit = wr_en && (idx == PTR_W'(i));
        always_comb begin
          val_d = val_q;
          if (hit) val_d = (val_q & ~MASK) | (wr_data & MASK);
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) val_q <= INIT;
          else        val_q <= val_d;
        end
        assign bytes[i] = val_q;
      end
      assign cfg_flat[i*BYTE_W +: BYTE_W] = bytes[i];
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < REG_COUNT; k++)
      if (idx == PTR_W'(k)) rd_data = bytes[k];
  end
endmodule

// File: rtl/smb_link_fsm.sv
module smb_link_fsm
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic [PTR_W-1:0]  idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam logic [PTR_W-1:0]  PTR_END = PTR_W'(REG_COUNT);
  localparam logic [BYTE_W-1:0] IDX_END = BYTE_W'(REG_COUNT);

  link_st_t          st_q, st_d;
  field_t            fd_q, fd_d;
  logic [3:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [BYTE_W-1:0] cnt_q, cnt_d;
  logic [BYTE_W-1:0] left_q, left_d;
  logic              rd_q, rd_d;
  logic              oe_q, oe_d;
  logic              scl_p, sda_p;
  logic              scl_rise, scl_fall, start_ev, stop_ev;
  logic [PTR_W-1:0]  ptr_inc;

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  assign ptr_inc  = (ptr_q == PTR_END) ? ptr_q : ptr_q + 1'b1;

  always_comb begin
    st_d = st_q; fd_d = fd_q; bit_d = bit_q; sh_d = sh_q; ptr_d = ptr_q;
    cnt_d = cnt_q; left_d = left_q; rd_d = rd_q; oe_d = oe_q;
    wr_en = 1'b0;
    if (start_ev) begin
      st_d = LK_RX; fd_d = FD_ADDR; bit_d = '0; oe_d = 1'b0; rd_d = 1'b0;
    end else if (stop_ev) begin
      st_d = LK_IDLE; oe_d = 1'b0;
    end else begin
      case (st_q)
        LK_RX: begin
          if (scl_rise && bit_q != 4'd8) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            bit_d = bit_q + 4'd1;
          end
          if (scl_fall && bit_q == 4'd8) begin
            st_d = LK_RX_ACK; oe_d = 1'b1; bit_d = '0;
            case (fd_q)
              FD_ADDR: begin
                if (sh_q[7:1] != DEV_ADDR) begin
                  st_d = LK_SKIP; oe_d = 1'b0;
                end else if (sh_q[0]) begin
                  rd_d = 1'b1; sh_d = cnt_q;
                end else begin
                  rd_d = 1'b0; fd_d = FD_INDEX;
                end
              end
              FD_INDEX: begin
                ptr_d = (sh_q >= IDX_END) ? PTR_END : sh_q[PTR_W-1:0];
                fd_d  = FD_COUNT;
              end
              FD_COUNT: begin
                cnt_d = sh_q; left_d = sh_q; fd_d = FD_DATA;
              end
              default: begin
                if (left_q != '0) begin
                  left_d = left_q - 1'b1;
                  wr_en  = (ptr_q < PTR_END);
                  ptr_d  = ptr_inc;
                end
              end
            endcase
          end
        end
        LK_RX_ACK: begin
          if (scl_fall) begin
            bit_d = '0;
            if (rd_q) begin st_d = LK_TX; oe_d = ~sh_q[7]; end
            else      begin st_d = LK_RX; oe_d = 1'b0; end
          end
        end
        LK_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              st_d = LK_TX_ACK; oe_d = 1'b0;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              bit_d = bit_q + 4'd1;
              oe_d  = ~sh_q[6];
            end
          end
        end
        LK_TX_ACK: begin
          if (scl_rise) begin
            if (!sda_s) begin sh_d = rd_data; ptr_d = ptr_inc; end
            else st_d = LK_SKIP;
          end else if (scl_fall) begin
            st_d = LK_TX; bit_d = '0; oe_d = ~sh_q[7];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LK_IDLE; fd_q <= FD_ADDR; bit_q <= '0; sh_q <= '0;
      ptr_q <= '0; cnt_q <= IDX_END; left_q <= '0; rd_q <= 1'b0;
      oe_q <= 1'b0; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      st_q <= st_d; fd_q <= fd_d; bit_q <= bit_d; sh_q <= sh_d;
      ptr_q <= ptr_d; cnt_q <= cnt_d; left_q <= left_d; rd_q <= rd_d;
      oe_q <= oe_d; scl_p <= scl_s; sda_p <= sda_s;
    end
  end

  assign idx     = ptr_q;
  assign wr_data = sh_q;
  assign sda_oe  = oe_q;
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter logic [3:0]  REV_ID      = 4'h2,
  parameter logic [3:0]  VEND_ID     = 4'h1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_i,
  input  logic                        sda_i,
  input  logic [1:0]                  fsel_i,
  output logic                        sda_oe_o,
  output logic [REG_COUNT*BYTE_W-1:0] cfg_o
);
  logic [1:0]        rst_pipe;
  logic              rst_q_n;
  logic [1:0]        line_s;
  logic [1:0]        fsel_s;
  logic              bank_we;
  logic [PTR_W-1:0]  bank_idx;
  logic [BYTE_W-1:0] bank_wd, bank_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  smb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_line_sync (
    .clk(clk), .rst_n(rst_q_n), .d_i({scl_i, sda_i}), .q_o(line_s));

  smb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_fsel_sync (
    .clk(clk), .rst_n(rst_q_n), .d_i(fsel_i), .q_o(fsel_s));

  smb_link_fsm #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_q_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .rd_data(bank_rd), .wr_en(bank_we), .idx(bank_idx),
    .wr_data(bank_wd), .sda_oe(sda_oe_o));

  smb_reg_bank #(.REV_ID(REV_ID), .VEND_ID(VEND_ID)) u_bank (
    .clk(clk), .rst_n(rst_q_n), .wr_en(bank_we), .idx(bank_idx),
    .wr_data(bank_wd), .fsel(fsel_s), .rd_data(bank_rd), .cfg_flat(cfg_o));
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
  import smb_cfg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_s,
  input logic             sda_oe,
  input logic             we,
  input logic [PTR_W-1:0] widx
);
  logic scl_p, sda_p;
  logic edge_ev, stop_c, fall_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin scl_p <= 1'b1; sda_p <= 1'b1; end
    else        begin scl_p <= scl_s; sda_p <= sda_s; end
  end
  assign stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  assign edge_ev = scl_s & scl_p & (sda_p ^ sda_s);
  assign fall_c  = ~scl_s & scl_p;

  // R11: drive changes only with SCL low, unless a start/stop released it
  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) && !$past(edge_ev)) |-> !scl_s);

  // R2: a new pull-low begins only right after an SCL fall
  assert_ack_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(fall_c));

  // R10: a stop always leaves SDA released
  assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_c) |-> !sda_oe);

  // R4: no write lands beyond the last register
  assert_write_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (widx < PTR_W'(REG_COUNT)));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
  .sda_oe(sda_oe_o), .we(bank_we), .widx(bank_idx));

// File: tb/sim_smb_cfg_slave.sv
`timescale 1ns/1ps
module sim_smb_cfg_slave;
  localparam int HALF = 10;
  logic clk, rst_n, scl_h, sda_h, sda_oe;
  logic [1:0] fsel;
  logic [63:0] cfg;
  wire sda_line = sda_h & ~sda_oe;
  int total, bad;
  bit finished;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic [7:0] rcount;
  logic wack, oe_nack;

  smb_cfg_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
                    .fsel_i(fsel), .sda_oe_o(sda_oe), .cfg_o(cfg));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [63:0] DEFAULTS = 64'h21_03_DF_C7_FF_00_47_02;
  // {index, data written, value expected back}
  localparam logic [23:0] VEC [8] = '{
    {8'd1, 8'hFF, 8'hC7}, {8'd1, 8'h00, 8'h00}, {8'd2, 8'hFF, 8'hF8},
    {8'd6, 8'hFF, 8'hB7}, {8'd3, 8'h5A, 8'h5A}, {8'd0, 8'hFF, 8'h02},
    {8'd7, 8'h00, 8'h21}, {8'd5, 8'hA5, 8'hA5}};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start;
    wclk(2); sda_h = 1'b1; wclk(HALF); scl_h = 1'b1; wclk(HALF);
    sda_h = 1'b0; wclk(HALF); scl_h = 1'b0;
  endtask

  task automatic do_stop;
    wclk(2); sda_h = 1'b0; wclk(HALF); scl_h = 1'b1; wclk(HALF);
    sda_h = 1'b1; wclk(HALF);
  endtask

  task automatic send_bit(input logic b);
    wclk(2); sda_h = b; wclk(HALF); scl_h = 1'b1; wclk(HALF); scl_h = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    wclk(2); sda_h = 1'b1; wclk(HALF); scl_h = 1'b1;
    wclk(2); s1 = ~sda_line; wclk(HALF - 4); s2 = ~sda_line; wclk(2);
    scl_h = 1'b0;
    chk("R11 ack level steady over SCL high", s2, s1);
    ack = s1;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic ack);
    for (int i = 7; i >= 0; i--) begin
      wclk(HALF); scl_h = 1'b1; wclk(HALF / 2); b[i] = sda_line;
      wclk(HALF / 2); scl_h = 1'b0;
    end
    wclk(2); sda_h = ~ack; wclk(HALF); scl_h = 1'b1; wclk(HALF);
    scl_h = 1'b0; wclk(2); sda_h = 1'b1;
  endtask

  task automatic write_frame(input logic [7:0] idx, input logic [7:0] cnt, input int nb);
    logic a;
    do_start;
    send_byte(8'hD2, a); wack = a;
    send_byte(idx, a);   wack &= a;
    send_byte(cnt, a);   wack &= a;
    for (int k = 0; k < nb; k++) begin send_byte(wbuf[k], a); wack &= a; end
    do_stop;
  endtask

  task automatic read_frame(input logic [7:0] idx, input int nb);
    logic a;
    do_start;
    send_byte(8'hD2, a); wack = a;
    send_byte(idx, a);   wack &= a;
    do_start;
    send_byte(8'hD3, a); wack &= a;
    recv_byte(rcount, 1'b1);
    for (int k = 0; k < nb; k++) recv_byte(rbuf[k], k != nb - 1);
    wclk(2); oe_nack = sda_oe;
    do_stop;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a;
    total = 0; bad = 0; finished = 0;
    rst_n = 1'b0; scl_h = 1'b1; sda_h = 1'b1; fsel = 2'b10;
    wclk(5); rst_n = 1'b1; wclk(10);
    chk("R9 R12 reset bank", cfg, DEFAULTS);
    chk("R9 SDA released at reset", sda_oe, 1'b0);

    read_frame(8'd0, 1);
    chk("R5 reset count echoed", rcount, 8'h08);
    chk("R7 fsel readback", rbuf[0], 8'h02);
    chk("R1 read frame acked", wack, 1'b1);

    foreach (VEC[v]) begin
      wbuf[0] = VEC[v][15:8];
      write_frame(VEC[v][23:16], 8'd1, 1);
      chk("R2 single write acked", wack, 1'b1);
      read_frame(VEC[v][23:16], 1);
      chk("R8 R7 readback after write", rbuf[0], VEC[v][7:0]);
      chk("R12 parallel byte", cfg[VEC[v][18:16]*8 +: 8], VEC[v][7:0]);
    end

    // R1: foreign address
    do_start; send_byte(8'hA0, a);
    chk("R1 foreign address not acked", a, 1'b0);
    send_byte(8'h03, a); send_byte(8'h01, a); send_byte(8'h77, a);
    chk("R1 ignored bytes not acked", a, 1'b0);
    do_stop;
    chk("R1 bank untouched", cfg[31:24], 8'h5A);

    // R2/R3: count 2, three data bytes
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    write_frame(8'd3, 8'd2, 3);
    chk("R3 extra byte still acked", wack, 1'b1);
    chk("R2 reg3", cfg[31:24], 8'h11);
    chk("R2 reg4", cfg[39:32], 8'h22);
    chk("R3 reg5 unchanged", cfg[47:40], 8'hA5);

    read_frame(8'd3, 2);
    chk("R5 count echoed", rcount, 8'h02);
    chk("R5 first byte", rbuf[0], 8'h11);
    chk("R5 second byte", rbuf[1], 8'h22);
    chk("R6 released after nack", oe_nack, 1'b0);

    // R4: run past the end
    wbuf[0] = 8'h44; wbuf[1] = 8'h55;
    write_frame(8'd7, 8'd2, 2);
    chk("R4 past-end writes acked", wack, 1'b1);
    chk("R4 bank unchanged", cfg, {8'h21, 8'hB7, 8'hA5, 8'h22, 8'h11, 8'hF8, 8'h00, 8'h02});
    read_frame(8'd9, 1);
    chk("R4 out-of-range reads 00", rbuf[0], 8'h00);
    read_frame(8'd6, 3);
    chk("R4 read reg6", rbuf[0], 8'hB7);
    chk("R4 read reg7", rbuf[1], 8'h21);
    chk("R4 read beyond end", rbuf[2], 8'h00);

    // R10: stop in the middle of a byte
    do_start;
    send_byte(8'hD2, a); send_byte(8'h04, a); send_byte(8'h02, a);
    send_byte(8'h66, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    do_stop;
    chk("R10 completed byte kept", cfg[39:32], 8'h66);
    chk("R10 partial byte dropped", cfg[47:40], 8'hA5);
    chk("R10 SDA released", sda_oe, 1'b0);
    wbuf[0] = 8'h3C;
    write_frame(8'd5, 8'd1, 1);
    chk("R10 next frame works", cfg[47:40], 8'h3C);

    // R9: reset again
    rst_n = 1'b0; wclk(3); rst_n = 1'b1; wclk(10);
    chk("R9 defaults after second reset", cfg, DEFAULTS);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule